// File: doc/BRIEF.md
# Memory Performance Event Counters

This block sits beside a memory controller and turns three status buses into a bank of saturating counters. A packed page-event word reports page hits and misses for eight open pages. Two level vectors report read activity: eight processor read slots and two system-bus read ports. For every page the block keeps a hit total and a miss total. For every read slot and port it keeps a count of the cycles the read was active and a count of completed reads. Average read latency is the cycle total divided by the completion total.

Software or a debug engine reads any counter through a one-cycle registered read port. A global enable pauses all counting. A clear strobe zeroes every counter on the next clock.

Top module: `memPerfMon`

## Requirements
- R1: After reset every counter is zero and `rdData` is zero.
- R2: When `pageEvent[4]` is 1, the counter selected by `pageEvent[2:0]` increments once in that cycle. It is the hit counter when `pageEvent[3]` is 1 and the miss counter when `pageEvent[3]` is 0. When `pageEvent[4]` is 0, no page counter changes.
- R3: Each activity bit has a cycle accumulator that increments on every clock in which the bit is 1. The bits are slot s = 0..7 for `cpuRdActive[s]`, slot 8 for `busRdActive[0]` (north port) and slot 9 for `busRdActive[1]` (south port).
- R4: Each slot's completion counter increments once per 1-to-0 transition of its activity bit between two consecutive clock samples.
- R5: Every counter saturates at its all-ones value and does not wrap. The widths are `PAGE_W` for page counters, `ACC_W` for cycle accumulators and `DONE_W` for completion counters.
- R6: While `enable` is 0, no counter changes. A falling edge that happens while disabled is not counted later.
- R7: When `clear` is 1, every counter is zero after that clock edge. Clear takes priority over any increment in the same cycle.
- R8: When `rdEn` is 1 at a clock edge, `rdData` takes the selected counter's value from before that edge's update, zero-extended. The address map is:
  - `rdAddr[5:4]`=0: page counters. Bit 3 set selects miss, clear selects hit; bits 2:0 give the page.
  - `rdAddr[5:4]`=1: cycle accumulator of slot `rdAddr[3:0]`.
  - `rdAddr[5:4]`=2: completion counter of slot `rdAddr[3:0]`.
  
  `rdData` holds its value while `rdEn` is 0.
- R9: An address with `rdAddr[5:4]`=3, or with a slot number of 10 or more, reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global count enable |
| clear | input | 1 | Zero all counters at the next edge |
| pageEvent | input | 5 | {valid, hit, page[2:0]} |
| cpuRdActive | input | 8 | Processor read slot active levels |
| busRdActive | input | 2 | Bus read active: bit1 south, bit0 north |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 6 | Counter select |
| rdData | output | DATA_W | Registered read result |

## Verification
A read can land in the same cycle in which the addressed counter increments, saturates or is cleared. R8 requires the read to return the value from before that edge. The random phase issues reads at random addresses while events, activity toggles, disabled cycles and occasional clears run. Directed cases place a read exactly on a clear and on an increment. A bench model updates its expected totals only after taking the pre-edge read value, so any read that returns the post-update value is reported.

// File: rtl/memPerfPkg.sv
package memPerfPkg;
  localparam int NUM_PAGES = 8;
  localparam int CPU_SLOTS = 8;
  localparam int NUM_SLOTS = CPU_SLOTS + 2;
  localparam int ADDR_W    = 6;

  typedef struct packed {
    logic                 clr;
    logic [NUM_PAGES-1:0] hitInc;
    logic [NUM_PAGES-1:0] missInc;
    logic [NUM_SLOTS-1:0] actInc;
    logic [NUM_SLOTS-1:0] doneInc;
  } perfStrobes_t;
endpackage

// File: rtl/perfSatCnt.sv
module perfSatCnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      count <= '0;
    else if (clr)                   count <= '0;
    else if (inc && (count != '1))  count <= count + 1'b1;
  end
endmodule

// File: rtl/perfCtrl.sv
module perfCtrl
  import memPerfPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic                 clear,
  input  logic [4:0]           pageEvent,
  input  logic [CPU_SLOTS-1:0] cpuRdActive,
  input  logic [1:0]           busRdActive,
  output perfStrobes_t         strb
);
  logic [NUM_SLOTS-1:0] actNow, actPrev;
  logic                 evValid, evHit;
  logic [2:0]           evPage;

  assign actNow  = {busRdActive[1], busRdActive[0], cpuRdActive};
  assign evValid = pageEvent[4];
  assign evHit   = pageEvent[3];
  assign evPage  = pageEvent[2:0];

  // previous level is tracked even while disabled so paused edges never count later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) actPrev <= '0;
    else       actPrev <= actNow;
  end

  always_comb begin
    strb.clr = clear;
    for (int p = 0; p < NUM_PAGES; p++) begin
      strb.hitInc[p]  = enable && evValid &&  evHit && (evPage == 3'(p));
      strb.missInc[p] = enable && evValid && !evHit && (evPage == 3'(p));
    end
    strb.actInc  = enable ? actNow : '0;
    strb.doneInc = enable ? (actPrev & ~actNow) : '0;
  end
endmodule

// File: rtl/perfDatapath.sv
module perfDatapath
  import memPerfPkg::*;
#(
  parameter int PAGE_W = 32,
  parameter int ACC_W  = 32,
  parameter int DONE_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  perfStrobes_t      strb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [PAGE_W-1:0] hitCnt  [NUM_PAGES];
  logic [PAGE_W-1:0] missCnt [NUM_PAGES];
  logic [ACC_W-1:0]  accCnt  [NUM_SLOTS];
  logic [DONE_W-1:0] doneCnt [NUM_SLOTS];

  for (genvar p = 0; p < NUM_PAGES; p++) begin : gPage
    perfSatCnt #(.W(PAGE_W)) uHit  (.clk(clk), .rstN(rstN), .clr(strb.clr),
                                    .inc(strb.hitInc[p]),  .count(hitCnt[p]));
    perfSatCnt #(.W(PAGE_W)) uMiss (.clk(clk), .rstN(rstN), .clr(strb.clr),
                                    .inc(strb.missInc[p]), .count(missCnt[p]));
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    perfSatCnt #(.W(ACC_W))  uAcc  (.clk(clk), .rstN(rstN), .clr(strb.clr),
                                    .inc(strb.actInc[s]),  .count(accCnt[s]));
    perfSatCnt #(.W(DONE_W)) uDone (.clk(clk), .rstN(rstN), .clr(strb.clr),
                                    .inc(strb.doneInc[s]), .count(doneCnt[s]));
  end

  logic [1:0]        region;
  logic [3:0]        slot;
  logic [DATA_W-1:0] selVal;

  assign region = rdAddr[5:4];
  assign slot   = rdAddr[3:0];

  always_comb begin
    selVal = '0;
    case (region)
      2'd0: selVal = slot[3] ? DATA_W'(missCnt[slot[2:0]]) : DATA_W'(hitCnt[slot[2:0]]);
      2'd1: if (slot < 4'(NUM_SLOTS)) selVal = DATA_W'(accCnt[slot]);
      2'd2: if (slot < 4'(NUM_SLOTS)) selVal = DATA_W'(doneCnt[slot]);
      default: selVal = '0;
    endcase
  end

  // registered read captures pre-update counter values
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= selVal;
  end
endmodule

// File: rtl/memPerfMon.sv
module memPerfMon
  import memPerfPkg::*;
#(
  parameter int PAGE_W = 32,
  parameter int ACC_W  = 32,
  parameter int DONE_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              clear,
  input  logic [4:0]        pageEvent,
  input  logic [7:0]        cpuRdActive,
  input  logic [1:0]        busRdActive,
  input  logic              rdEn,
  input  logic [5:0]        rdAddr,
  output logic [DATA_W-1:0] rdData
);
  perfStrobes_t strb;

  perfCtrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .clear(clear),
    .pageEvent(pageEvent), .cpuRdActive(cpuRdActive),
    .busRdActive(busRdActive), .strb(strb)
  );

  perfDatapath #(.PAGE_W(PAGE_W), .ACC_W(ACC_W), .DONE_W(DONE_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/memPerfMonChk.sv
module memPerfMonChk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              clear,
  input logic              rdEn,
  input logic [5:0]        rdAddr,
  input logic [DATA_W-1:0] rdData
);
  logic unmapped;
  assign unmapped = (rdAddr[5:4] == 2'd3) || ((rdAddr[5:4] != 2'd0) && (rdAddr[3:0] >= 4'd10));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && unmapped) |=> (rdData == '0));

  a_r7_clear_then_read: assert property (@(posedge clk) disable iff (!rstN)
    clear ##1 rdEn |=> (rdData == '0));

  a_r6_disabled_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !enable && !clear) ##1 (rdEn && $stable(rdAddr)) |=> $stable(rdData));

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !clear) ##1 (rdEn && $stable(rdAddr)) |=> (rdData >= $past(rdData)));

  // R2, R3, R4: any counter moves by at most one per cycle
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !clear) ##1 (rdEn && $stable(rdAddr)) |=> ((rdData - $past(rdData)) <= 1));
endmodule

bind memPerfMon memPerfMonChk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .clear(clear),
  .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/sim_memPerfMon.sv
`timescale 1ns/1ps
module sim_memPerfMon;
  localparam int PAGE_W = 6;
  localparam int ACC_W  = 8;
  localparam int DONE_W = 3;
  localparam int DATA_W = 32;
  localparam int PMAX = (1 << PAGE_W) - 1;
  localparam int AMAX = (1 << ACC_W) - 1;
  localparam int DMAX = (1 << DONE_W) - 1;

  logic clk = 0, rstN = 0, enable = 0, clear = 0, rdEn = 0;
  logic [4:0] pageEvent = '0;
  logic [7:0] cpuRdActive = '0;
  logic [1:0] busRdActive = '0;
  logic [5:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;

  always #2.5 clk = ~clk;

  memPerfMon #(.PAGE_W(PAGE_W), .ACC_W(ACC_W), .DONE_W(DONE_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .clear(clear), .pageEvent(pageEvent),
    .cpuRdActive(cpuRdActive), .busRdActive(busRdActive),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  int nChecks = 0, nFails = 0;
  int expHit[8], expMiss[8], expAcc[10], expDone[10];
  logic [9:0] mPrev = '0;
  logic [DATA_W-1:0] expRd = '0;

  function automatic int sat(int v, int mx);
    return (v >= mx) ? mx : v + 1;
  endfunction

  function automatic int modelRead(logic [5:0] a);
    int s = int'(a[3:0]);
    case (a[5:4])
      2'd0: return a[3] ? expMiss[a[2:0]] : expHit[a[2:0]];
      2'd1: return (s < 10) ? expAcc[s] : 0;
      2'd2: return (s < 10) ? expDone[s] : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string reqOf(logic [5:0] a);
    if (a[5:4] == 2'd3 || (a[5:4] != 2'd0 && a[3:0] >= 4'd10)) return "R9";
    case (a[5:4])
      2'd0: return "R2";
      2'd1: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model update, sample at next negedge
  task automatic step(logic en, logic clr, logic [4:0] ev, logic [7:0] cpu, logic [1:0] bus,
                      logic re, logic [5:0] ra, string tag);
    logic [9:0] act;
    enable = en; clear = clr; pageEvent = ev; cpuRdActive = cpu;
    busRdActive = bus; rdEn = re; rdAddr = ra;
    if (re) expRd = DATA_W'(modelRead(ra));
    @(posedge clk);
    act = {bus, cpu};
    if (clr) begin
      for (int i = 0; i < 8; i++) begin expHit[i] = 0; expMiss[i] = 0; end
      for (int i = 0; i < 10; i++) begin expAcc[i] = 0; expDone[i] = 0; end
    end else if (en) begin
      if (ev[4]) begin
        if (ev[3]) expHit[ev[2:0]] = sat(expHit[ev[2:0]], PMAX);
        else       expMiss[ev[2:0]] = sat(expMiss[ev[2:0]], PMAX);
      end
      for (int i = 0; i < 10; i++) begin
        if (act[i]) expAcc[i] = sat(expAcc[i], AMAX);
        if (mPrev[i] && !act[i]) expDone[i] = sat(expDone[i], DMAX);
      end
    end
    mPrev = act;
    @(negedge clk);
    if (re) check((tag != "") ? tag : reqOf(ra), rdData, expRd);
    else    check("R8 hold", rdData, expRd);
  endtask

  task automatic idle(logic en, logic [7:0] cpu, logic [1:0] bus);
    step(en, 0, 5'd0, cpu, bus, 0, 6'd0, "");
  endtask

  task automatic readAll(string tag);
    for (int a = 0; a < 64; a++) step(0, 0, 5'd0, cpuRdActive, busRdActive, 1, 6'(a), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] cpu;
    logic [1:0] bus;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin expHit[i] = 0; expMiss[i] = 0; end
    for (int i = 0; i < 10; i++) begin expAcc[i] = 0; expDone[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    check("R1", rdData, '0);
    readAll("R1");

    // R2: hits on page 3, misses on page 5, invalid events ignored
    repeat (4) step(1, 0, 5'b11_011, 8'h0, 2'b0, 0, 0, "");
    repeat (2) step(1, 0, 5'b10_101, 8'h0, 2'b0, 0, 0, "");
    repeat (3) step(1, 0, 5'b01_010, 8'h0, 2'b0, 0, 0, "");
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd3,  "R2");
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd13, "R2");
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd2,  "R2");
    // read in the same cycle as an increment returns the old value (R8)
    step(1, 0, 5'b11_011, 8'h0, 2'b0, 1, 6'd3, "R8");
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd3, "R8");

    // R3/R4: latency and completions on cpu slot 2 and south port
    repeat (5) idle(1, 8'h04, 2'b10);
    idle(1, 8'h00, 2'b00);
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd18, "R3");
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd25, "R3");
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd34, "R4");
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd41, "R4");

    // R6: disabled, falling edge while paused not counted later
    idle(1, 8'h01, 2'b00);
    repeat (3) step(0, 0, 5'b11_000, 8'h01, 2'b00, 0, 0, "");
    step(0, 0, 5'b11_000, 8'h00, 2'b00, 0, 0, "");
    repeat (2) idle(1, 8'h00, 2'b00);
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd32, "R6");
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd16, "R6");
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd0,  "R6");

    // R5: saturation of each counter kind
    repeat (PMAX + 6) step(1, 0, 5'b11_001, 8'h0, 2'b0, 0, 0, "");
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd1, "R5");
    repeat (AMAX + 6) idle(1, 8'h00, 2'b01);
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd24, "R5");
    for (int k = 0; k < DMAX + 3; k++) begin idle(1, 8'h80, 2'b0); idle(1, 8'h00, 2'b0); end
    step(1, 0, 5'b0, 8'h0, 2'b0, 1, 6'd39, "R5");

    // R7: clear with concurrent increments; read on the clear returns old value
    step(1, 1, 5'b11_001, 8'hFF, 2'b11, 1, 6'd1, "R7");
    step(1, 0, 5'b0, 8'hFF, 2'b11, 1, 6'd1, "R7");
    step(1, 0, 5'b0, 8'h00, 2'b00, 1, 6'd24, "R7");
    readAll("");

    // random phase
    cpu = '0; bus = '0;
    for (int n = 0; n < 4000; n++) begin
      cpu ^= 8'($urandom & $urandom & $urandom);
      bus ^= 2'($urandom & $urandom);
      step(($urandom % 8) != 0, ($urandom % 300) == 0, 5'($urandom), cpu, bus,
           ($urandom % 2) == 0, 6'($urandom), "");
    end
    readAll("");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule